// File: doc/BRIEF.md
# Two-Port Synchronous Word Memory with Byte Lanes

This block is a true two-port synchronous memory of 16-bit words. Each side (left and right) has its own clock and registers its address, write data and controls on that clock's rising edge. A side is picked by a pair of chip enables. Two active-low lane selects gate the high and low bytes for both writing and reading. A side's tri-state bus is modelled as a data-out word plus one drive-enable bit per byte lane. An active-low output enable gates those bits without passing through a register. The address comes from outside; burst address generation belongs to a neighbouring block.

Each side has a static `pipe` mode input. With `pipe` low (flow-through), read data shows up in the cycle after the address edge. With `pipe` high (pipelined), it shows up one cycle later. The registered controls move through an access state: IDLE, READ or WRITE. This state is decoded at the input edge and moves from stage one to stage two on each edge. In flow-through mode the outputs take the stage-one state. In pipelined mode they take the stage-two state, so a deselect takes two edges to reach the bus. The lane selects always act from stage one.

A write is committed to the array on the next edge after the edge that registered it. The full size is `ADDR_W = 15` (32K words); the default is smaller.

Top module: `dpram_byte_lanes`

## Requirements
- R1: In flow-through mode (`pipe`=0), a word written with both lane selects low reads back whole. Read data and drive enables are valid in the cycle after the edge that registers the read address.
- R2: In pipelined mode (`pipe`=1), read data and drive enables appear one cycle later than in flow-through mode.
- R3: A side is selected only when `ce0_n`=0 and `ce1`=1. With any other pair, a write does not change memory and a read drives no lane.
- R4: With `rw`=0 only the enabled lanes are written. `ub_n` low enables bits 15..8; `lb_n` low enables bits 7..0. If both are high, nothing is written.
- R5: With `rw`=1 only the enabled lanes are driven: `den[1]` follows `ub_n` and `den[0]` follows `lb_n`. A write cycle drives no lane.
- R6: `oe_n` high forces both drive enables to 0 without waiting for a clock edge. Lowering it restores them within the same cycle.
- R7: Deselection clears the drive enables one cycle after its edge in flow-through mode and two cycles after in pipelined mode.
- R8: In both modes the lane selects act from a single register stage. In pipelined mode, the lanes driven for a read follow the selects registered one edge after that read.
- R9: When both sides write the same address in the same cycle, each lane that both enable takes the left side's data. A lane enabled by one side only takes that side's data.
- R10: A read on one side of the address the other side writes in the same cycle returns the previous contents.
- R11: During and right after reset, no lane is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_l | input | 1 | Left side clock |
| clk_r | input | 1 | Right side clock |
| rst_n | input | 1 | Asynchronous active-low reset of the control registers |
| l_ce0_n | input | 1 | Left chip enable, active low |
| l_ce1 | input | 1 | Left chip enable, active high |
| l_rw | input | 1 | Left read (1) / write (0) |
| l_ub_n | input | 1 | Left high-byte select, active low |
| l_lb_n | input | 1 | Left low-byte select, active low |
| l_oe_n | input | 1 | Left output enable, active low, unclocked |
| l_pipe | input | 1 | Left read mode: 0 flow-through, 1 pipelined |
| l_addr | input | ADDR_W | Left word address |
| l_wdata | input | 2*LANE_W | Left write data |
| l_rdata | output | 2*LANE_W | Left read data |
| l_den | output | 2 | Left drive enables, bit 1 high byte, bit 0 low byte |
| r_ce0_n | input | 1 | Right chip enable, active low |
| r_ce1 | input | 1 | Right chip enable, active high |
| r_rw | input | 1 | Right read (1) / write (0) |
| r_ub_n | input | 1 | Right high-byte select, active low |
| r_lb_n | input | 1 | Right low-byte select, active low |
| r_oe_n | input | 1 | Right output enable, active low, unclocked |
| r_pipe | input | 1 | Right read mode: 0 flow-through, 1 pipelined |
| r_addr | input | ADDR_W | Right word address |
| r_wdata | input | 2*LANE_W | Right write data |
| r_rdata | output | 2*LANE_W | Right read data |
| r_den | output | 2 | Right drive enables, bit 1 high byte, bit 0 low byte |

## Verification
The bench builds the block with `ADDR_W = 6` and `LANE_W = 8`: a 64-word array whose contents a small reference model can track in full. Both side clocks come from one source. That places left and right accesses on the same edge, so same-address write collisions and read-during-write cases can be set up on demand. The bench switches `pipe` on each side during the run, which puts both read latencies and both deselect delays within reach.

// File: rtl/dpram_pkg.sv
package dpram_pkg;

    // Two byte lanes per word, one per lane select.
    localparam int LANES = 2;

    // Access decoded from the registered controls of one side.
    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_e;

endpackage

// File: rtl/dpram_port.sv
module dpram_port
    import dpram_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int LANE_W = 8
) (
    input  logic                       clk_i,
    input  logic                       rst_n,
    input  logic                       ce0_n_i,
    input  logic                       ce1_i,
    input  logic                       rw_i,
    input  logic                       ub_n_i,
    input  logic                       lb_n_i,
    input  logic                       oe_n_i,
    input  logic                       pipe_i,
    input  logic [ADDR_W-1:0]          addr_i,
    input  logic [LANES*LANE_W-1:0]    wdata_i,
    input  logic [LANES*LANE_W-1:0]    rd_word_i,
    output logic [ADDR_W-1:0]          mem_addr_o,
    output logic [LANES*LANE_W-1:0]    wr_data_o,
    output logic [LANES-1:0]           wr_lane_o,
    output logic                       wr_tog_o,
    output logic [LANES*LANE_W-1:0]    rdata_o,
    output logic [LANES-1:0]           den_o
);

    localparam int DATA_W = LANES * LANE_W;

    acc_e                acc_in;
    acc_e                acc_s1;
    acc_e                acc_s2;
    logic                selected;
    logic [LANES-1:0]    lane_in;
    logic [LANES-1:0]    lane_s1;
    logic [ADDR_W-1:0]   addr_s1;
    logic [DATA_W-1:0]   wdata_s1;
    logic [DATA_W-1:0]   rword_s2;
    logic                tog_q;
    logic                read_live;

    // Input decode: access kind and active lanes.
    always_comb begin
        selected = !ce0_n_i && ce1_i;
        lane_in  = {!ub_n_i, !lb_n_i};
        if (!selected) begin
            acc_in = ACC_IDLE;
        end else if (rw_i) begin
            acc_in = ACC_READ;
        end else begin
            acc_in = ACC_WRITE;
        end
    end

    // Stage registers: access state moves stage one -> stage two each edge.
    always_ff @(posedge clk_i or negedge rst_n) begin
        if (!rst_n) begin
            acc_s1   <= ACC_IDLE;
            acc_s2   <= ACC_IDLE;
            addr_s1  <= '0;
            wdata_s1 <= '0;
            lane_s1  <= '0;
            rword_s2 <= '0;
            tog_q    <= 1'b0;
        end else begin
            acc_s1   <= acc_in;
            acc_s2   <= acc_s1;
            addr_s1  <= addr_i;
            wdata_s1 <= wdata_i;
            lane_s1  <= lane_in;
            rword_s2 <= rd_word_i;
            if (acc_in == ACC_WRITE && lane_in != '0) begin
                tog_q <= !tog_q;
            end
        end
    end

    assign mem_addr_o = addr_s1;
    assign wr_data_o  = wdata_s1;
    assign wr_lane_o  = lane_s1;
    assign wr_tog_o   = tog_q;

    // Output selection by read mode; lanes always from stage one.
    always_comb begin
        unique case (pipe_i)
            1'b0: begin
                read_live = (acc_s1 == ACC_READ);
                rdata_o   = rd_word_i;
            end
            1'b1: begin
                read_live = (acc_s2 == ACC_READ);
                rdata_o   = rword_s2;
            end
            default: begin
                read_live = 1'b0;
                rdata_o   = rd_word_i;
            end
        endcase
        den_o = (!oe_n_i && read_live) ? lane_s1 : '0;
    end

    logic desel_in;
    assign desel_in = !(!ce0_n_i && ce1_i);

    AST_OE_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_n)
        oe_n_i |-> (den_o == '0)); // R6

    AST_HI_LANE_ONE_STAGE: assert property (@(posedge clk_i) disable iff (!rst_n)
        den_o[1] |-> $past(!ub_n_i)); // R8

    AST_LO_LANE_ONE_STAGE: assert property (@(posedge clk_i) disable iff (!rst_n)
        den_o[0] |-> $past(!lb_n_i)); // R8

    AST_FT_DESEL: assert property (@(posedge clk_i) disable iff (!rst_n)
        (!pipe_i && desel_in) |=> (pipe_i || den_o == '0)); // R7

    AST_PIPE_DESEL: assert property (@(posedge clk_i) disable iff (!rst_n)
        (pipe_i && desel_in) |-> ##2 (!pipe_i || den_o == '0)); // R7

    AST_WRITE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_n)
        (!pipe_i && !desel_in && !rw_i) |=> (pipe_i || den_o == '0)); // R5

endmodule

// File: rtl/dpram_array.sv
module dpram_array
    import dpram_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int LANE_W = 8
) (
    input  logic                     clk_a_i,
    input  logic                     clk_b_i,
    input  logic                     rst_n,
    input  logic                     tog_a_i,
    input  logic [ADDR_W-1:0]        addr_a_i,
    input  logic [LANES*LANE_W-1:0]  data_a_i,
    input  logic [LANES-1:0]         lane_a_i,
    input  logic                     tog_b_i,
    input  logic [ADDR_W-1:0]        addr_b_i,
    input  logic [LANES*LANE_W-1:0]  data_b_i,
    input  logic [LANES-1:0]         lane_b_i,
    output logic [LANES*LANE_W-1:0]  rword_a_o,
    output logic [LANES*LANE_W-1:0]  rword_b_o
);

    localparam int DATA_W = LANES * LANE_W;
    localparam int DEPTH  = 1 << ADDR_W;

    logic [DATA_W-1:0] store [DEPTH];
    logic              seen_a;
    logic              seen_b;
    logic              pend_a;
    logic              pend_b;

    // A toggle that differs from its seen copy marks one pending write.
    assign pend_a = tog_a_i ^ seen_a;
    assign pend_b = tog_b_i ^ seen_b;

    always_ff @(posedge clk_a_i or posedge clk_b_i or negedge rst_n) begin
        if (!rst_n) begin
            seen_a <= 1'b0;
            seen_b <= 1'b0;
        end else begin
            seen_a <= tog_a_i;
            seen_b <= tog_b_i;
        end
    end

    // Side A is applied last, so it owns any lane both sides write.
    always_ff @(posedge clk_a_i or posedge clk_b_i) begin
        for (int ln = 0; ln < LANES; ln++) begin
            if (pend_b && lane_b_i[ln]) begin
                store[addr_b_i][ln*LANE_W +: LANE_W] <= data_b_i[ln*LANE_W +: LANE_W];
            end
            if (pend_a && lane_a_i[ln]) begin
                store[addr_a_i][ln*LANE_W +: LANE_W] <= data_a_i[ln*LANE_W +: LANE_W];
            end
        end
    end

    assign rword_a_o = store[addr_a_i];
    assign rword_b_o = store[addr_b_i];

endmodule

// File: rtl/dpram_byte_lanes.sv
module dpram_byte_lanes
    import dpram_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int LANE_W = 8
) (
    input  logic                     clk_l,
    input  logic                     clk_r,
    input  logic                     rst_n,
    input  logic                     l_ce0_n,
    input  logic                     l_ce1,
    input  logic                     l_rw,
    input  logic                     l_ub_n,
    input  logic                     l_lb_n,
    input  logic                     l_oe_n,
    input  logic                     l_pipe,
    input  logic [ADDR_W-1:0]        l_addr,
    input  logic [2*LANE_W-1:0]      l_wdata,
    output logic [2*LANE_W-1:0]      l_rdata,
    output logic [1:0]               l_den,
    input  logic                     r_ce0_n,
    input  logic                     r_ce1,
    input  logic                     r_rw,
    input  logic                     r_ub_n,
    input  logic                     r_lb_n,
    input  logic                     r_oe_n,
    input  logic                     r_pipe,
    input  logic [ADDR_W-1:0]        r_addr,
    input  logic [2*LANE_W-1:0]      r_wdata,
    output logic [2*LANE_W-1:0]      r_rdata,
    output logic [1:0]               r_den
);

    localparam int DATA_W = LANES * LANE_W;

    logic [ADDR_W-1:0] l_maddr, r_maddr;
    logic [DATA_W-1:0] l_mdata, r_mdata, l_rword, r_rword;
    logic [LANES-1:0]  l_mlane, r_mlane;
    logic              l_tog, r_tog;

    dpram_port #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_left (
        .clk_i(clk_l), .rst_n(rst_n),
        .ce0_n_i(l_ce0_n), .ce1_i(l_ce1), .rw_i(l_rw),
        .ub_n_i(l_ub_n), .lb_n_i(l_lb_n), .oe_n_i(l_oe_n), .pipe_i(l_pipe),
        .addr_i(l_addr), .wdata_i(l_wdata), .rd_word_i(l_rword),
        .mem_addr_o(l_maddr), .wr_data_o(l_mdata), .wr_lane_o(l_mlane),
        .wr_tog_o(l_tog), .rdata_o(l_rdata), .den_o(l_den)
    );

    dpram_port #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_right (
        .clk_i(clk_r), .rst_n(rst_n),
        .ce0_n_i(r_ce0_n), .ce1_i(r_ce1), .rw_i(r_rw),
        .ub_n_i(r_ub_n), .lb_n_i(r_lb_n), .oe_n_i(r_oe_n), .pipe_i(r_pipe),
        .addr_i(r_addr), .wdata_i(r_wdata), .rd_word_i(r_rword),
        .mem_addr_o(r_maddr), .wr_data_o(r_mdata), .wr_lane_o(r_mlane),
        .wr_tog_o(r_tog), .rdata_o(r_rdata), .den_o(r_den)
    );

    // Left side is side A: it wins lanes both sides write (R9).
    dpram_array #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_store (
        .clk_a_i(clk_l), .clk_b_i(clk_r), .rst_n(rst_n),
        .tog_a_i(l_tog), .addr_a_i(l_maddr), .data_a_i(l_mdata), .lane_a_i(l_mlane),
        .tog_b_i(r_tog), .addr_b_i(r_maddr), .data_b_i(r_mdata), .lane_b_i(r_mlane),
        .rword_a_o(l_rword), .rword_b_o(r_rword)
    );

    AST_RESET_QUIET: assert property (@(posedge clk_l)
        !rst_n |-> (l_den == 2'b00 && r_den == 2'b00)); // R11

endmodule

// File: tb/dpram_byte_lanes_bench.sv
module dpram_byte_lanes_bench;

    localparam int AW = 6;
    localparam int LW = 8;

    typedef struct {
        int         side;
        logic [15:0] data;
        logic [1:0]  den;
        string       req;
    } item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = !clk;

    logic        ce0n [2];
    logic        ce1  [2];
    logic        rw   [2];
    logic        ubn  [2];
    logic        lbn  [2];
    logic        oen  [2];
    logic        pipe [2];
    logic [AW-1:0] addr [2];
    logic [15:0] wd   [2];
    logic [15:0] rdl, rdr;
    logic [1:0]  denl, denr;

    dpram_byte_lanes #(.ADDR_W(AW), .LANE_W(LW)) u_dpram_byte_lanes (
        .clk_l(clk), .clk_r(clk), .rst_n(rst_n),
        .l_ce0_n(ce0n[0]), .l_ce1(ce1[0]), .l_rw(rw[0]), .l_ub_n(ubn[0]), .l_lb_n(lbn[0]),
        .l_oe_n(oen[0]), .l_pipe(pipe[0]), .l_addr(addr[0]), .l_wdata(wd[0]),
        .l_rdata(rdl), .l_den(denl),
        .r_ce0_n(ce0n[1]), .r_ce1(ce1[1]), .r_rw(rw[1]), .r_ub_n(ubn[1]), .r_lb_n(lbn[1]),
        .r_oe_n(oen[1]), .r_pipe(pipe[1]), .r_addr(addr[1]), .r_wdata(wd[1]),
        .r_rdata(rdr), .r_den(denr)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    item_t sb [$];

    // Reference model state (0 idle, 1 read, 2 write).
    logic [15:0] mm [1<<AW];
    int          op1 [2];
    int          op2 [2];
    logic [AW-1:0] a1 [2];
    logic [1:0]  be1 [2];
    logic [15:0] d2  [2];
    logic [15:0] wdat [2];
    bit          pend [2];

    task automatic check(input bit ok, input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Driver: model one edge and push expected outputs of both sides.
    task automatic step(input string req);
        logic [15:0] dn [2];
        @(posedge clk);
        #1;
        for (int p = 0; p < 2; p++) dn[p] = mm[a1[p]];
        for (int p = 1; p >= 0; p--) begin
            if (pend[p]) begin
                if (be1[p][1]) mm[a1[p]][15:8] = wdat[p][15:8];
                if (be1[p][0]) mm[a1[p]][7:0]  = wdat[p][7:0];
            end
        end
        for (int p = 0; p < 2; p++) begin
            op2[p]  = op1[p];
            op1[p]  = (!ce0n[p] && ce1[p]) ? (rw[p] ? 1 : 2) : 0;
            a1[p]   = addr[p];
            be1[p]  = {!ubn[p], !lbn[p]};
            wdat[p] = wd[p];
            pend[p] = (op1[p] == 2) && (be1[p] != 2'b00);
            d2[p]   = dn[p];
        end
        for (int p = 0; p < 2; p++) begin
            item_t it;
            bit live;
            live    = pipe[p] ? (op2[p] == 1) : (op1[p] == 1);
            it.side = p;
            it.den  = (!oen[p] && live) ? be1[p] : 2'b00;
            it.data = pipe[p] ? d2[p] : mm[a1[p]];
            it.req  = req;
            sb.push_back(it);
        end
        @(negedge clk);
    endtask

    // Monitor: compare away from the edge.
    initial begin
        forever begin
            @(posedge clk);
            #5;
            while (sb.size() > 0) begin
                item_t it;
                logic [15:0] ad;
                logic [1:0]  ae;
                logic [15:0] m;
                it = sb.pop_front();
                ad = (it.side == 0) ? rdl : rdr;
                ae = (it.side == 0) ? denl : denr;
                check(ae == it.den, it.req, (it.side == 0) ? "left den" : "right den",
                      {14'd0, ae}, {14'd0, it.den});
                if (it.den != 2'b00) begin
                    m = {{8{it.den[1]}}, {8{it.den[0]}}};
                    check((ad & m) == (it.data & m), it.req,
                          (it.side == 0) ? "left data" : "right data", ad & m, it.data & m);
                end
            end
        end
    end

    task automatic idle(input int p);
        ce0n[p] = 1'b1; ce1[p] = 1'b0; rw[p] = 1'b1; ubn[p] = 1'b1; lbn[p] = 1'b1;
    endtask

    task automatic wr(input int p, input logic [AW-1:0] a, input logic [15:0] d,
                      input logic ub, input logic lb);
        ce0n[p] = 1'b0; ce1[p] = 1'b1; rw[p] = 1'b0; ubn[p] = ub; lbn[p] = lb;
        addr[p] = a; wd[p] = d;
    endtask

    task automatic rd(input int p, input logic [AW-1:0] a, input logic ub, input logic lb);
        ce0n[p] = 1'b0; ce1[p] = 1'b1; rw[p] = 1'b1; ubn[p] = ub; lbn[p] = lb;
        addr[p] = a;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run hung actual=1 expected=0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < (1 << AW); i++) mm[i] = 16'h0000;
        for (int p = 0; p < 2; p++) begin
            idle(p);
            oen[p] = 1'b0; pipe[p] = 1'b0; addr[p] = '0; wd[p] = '0;
            op1[p] = 0; op2[p] = 0; a1[p] = '0; be1[p] = 2'b00; d2[p] = '0;
            wdat[p] = '0; pend[p] = 1'b0;
        end
        repeat (3) @(negedge clk);
        check(denl == 2'b00 && denr == 2'b00, "R11", "den in reset", {12'd0, denl, denr}, 16'd0);
        rst_n = 1'b1;
        // Preload every address used below with both lanes.
        for (int i = 0; i < 16; i++) begin
            wr(1, i[AW-1:0], 16'h0101 * i[15:0], 1'b0, 1'b0);
            step("R11");
        end
        idle(1);

        // R1: whole-word write and flow-through read.
        wr(0, 5, 16'hA1B2, 1'b0, 1'b0); step("R1");
        rd(0, 5, 1'b0, 1'b0);           step("R1");
        idle(0);                        step("R1");

        // R4: high-lane-only write, then low-lane-only, then none.
        wr(1, 5, 16'h7700, 1'b0, 1'b1); step("R4");
        wr(1, 6, 16'h00CC, 1'b1, 1'b0); step("R4");
        wr(1, 7, 16'hFFFF, 1'b1, 1'b1); step("R4");
        rd(1, 5, 1'b0, 1'b0);           step("R4");
        rd(1, 6, 1'b0, 1'b0);           step("R4");
        rd(1, 7, 1'b0, 1'b0);           step("R4");

        // R5: single-lane reads and a write drives nothing.
        rd(1, 5, 1'b0, 1'b1);           step("R5");
        rd(1, 5, 1'b1, 1'b0);           step("R5");
        wr(1, 8, 16'h1234, 1'b0, 1'b0); step("R5");
        idle(1);                        step("R5");

        // R3: every deselecting chip-enable pair blocks writes and reads.
        wr(0, 5, 16'h5555, 1'b0, 1'b0); ce0n[0] = 1'b1; step("R3");
        wr(0, 5, 16'h6666, 1'b0, 1'b0); ce1[0] = 1'b0;  step("R3");
        rd(0, 5, 1'b0, 1'b0); ce0n[0] = 1'b1; ce1[0] = 1'b0; step("R3");
        rd(0, 5, 1'b0, 1'b0);           step("R3");

        // R6: output enable gates the bus without a clock edge.
        oen[0] = 1'b1;                  step("R6");
        oen[0] = 1'b0;                  step("R6");
        #2;
        oen[0] = 1'b1;
        #2;
        check(denl == 2'b00, "R6", "left den after oe_n rise", {14'd0, denl}, 16'd0);
        oen[0] = 1'b0;
        #2;
        check(denl == 2'b11, "R6", "left den after oe_n fall", {14'd0, denl}, 16'h0003);
        @(negedge clk);
        idle(0);                        step("R6");

        // R9: simultaneous writes to one address.
        wr(0, 9, 16'h1111, 1'b0, 1'b0);  wr(1, 9, 16'h2222, 1'b0, 1'b0);  step("R9");
        wr(0, 10, 16'h0033, 1'b1, 1'b0); wr(1, 10, 16'h4444, 1'b0, 1'b0); step("R9");
        idle(1);
        rd(0, 9, 1'b0, 1'b0);            step("R9");
        rd(0, 10, 1'b0, 1'b0);           step("R9");

        // R10: read during the other side's write sees old data.
        wr(0, 5, 16'hDEAD, 1'b0, 1'b0); rd(1, 5, 1'b0, 1'b0); step("R10");
        idle(0);                        step("R10");
        idle(1);                        step("R10");

        // R2: pipelined latency.
        pipe[0] = 1'b1; pipe[1] = 1'b1;
        idle(0);                        step("R2");
        rd(0, 9, 1'b0, 1'b0);           step("R2");
        rd(0, 10, 1'b0, 1'b0);          step("R2");
        idle(0); ubn[0] = 1'b0; lbn[0] = 1'b0; step("R2");

        // R7: deselect in pipelined mode lasts one more cycle than flow-through.
        rd(1, 6, 1'b0, 1'b0);           step("R7");
        idle(1);                        step("R7");
        step("R7");
        pipe[1] = 1'b0;
        rd(1, 6, 1'b0, 1'b0);           step("R7");
        idle(1);                        step("R7");
        pipe[1] = 1'b1;

        // R8: lane selects act from one stage in pipelined mode.
        rd(0, 10, 1'b1, 1'b1);          step("R8");
        idle(0); ubn[0] = 1'b0; lbn[0] = 1'b1; step("R8");
        rd(0, 9, 1'b0, 1'b0);           step("R8");
        idle(0); ubn[0] = 1'b1; lbn[0] = 1'b0; step("R8");
        idle(0);                        step("R8");

        // R10 in pipelined mode.
        wr(1, 12, 16'hBEEF, 1'b0, 1'b0); rd(0, 12, 1'b0, 1'b0); step("R10");
        idle(1); rd(0, 12, 1'b0, 1'b0); step("R10");
        idle(0);                        step("R10");
        step("R10");

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule